// File: doc/BRIEF.md
# 10 Mb/s Receive Nibble Formatter

This block turns the serial bit stream from a 10 Mb/s receive bit recovery stage into the 4-bit media independent interface (MII) receive signals. Each recovered bit comes with a one-clock strobe. A one-clock end-of-frame pulse closes the frame. The block finds the start-of-frame delimiter in the alternating preamble and packs bits into nibbles. It drives `rxd`, `rx_dv` and `crs`, handing over one nibble on each 2.5 MHz nibble enable.

Two static mode pins set the behaviour. `pass_pre` chooses whether the preamble is removed or forwarded. `crs_align` chooses whether carrier sense drops with the end-of-frame pulse or with the fall of `rx_dv`. A fractional byte at the end of the frame (1 to 7 dribble bits) is either padded out to one nibble or cut back to one nibble. A small nibble queue takes up the phase difference between the bit strobes and the nibble enables.

Top module: `rx_nibble_fmt`

## Requirements
- R1: Bits are packed least-significant bit first: the first bit received of each group of four becomes `rxd[0]`. Each byte goes out low nibble first. While `rx_dv` is high, a new nibble appears on the clock edge where `nib_en` is high.
- R2: With `pass_pre`=0, `rx_dv` stays low during the preamble. The first two nibbles after `rx_dv` rises are 0x5 and then 0xD, followed by the frame body. `crs` rises one clock after the strobe of the second 1 of the closing "11" bit pair, which is before `rx_dv` rises.
- R3: With `pass_pre`=1, every bit from the first preamble bit (a 1) onward is output, and `crs` rises on the same clock as `rx_dv`.
- R4: With `crs_align`=0, `crs` falls one clock after the `eof_in` pulse, and `rx_dv` falls later, on the first `nib_en` clock after the last nibble has been shown.
- R5: With `crs_align`=1, `crs` falls on the same clock as `rx_dv`.
- R6: If 1 to 3 bits follow the last full byte, one extra nibble is output with those bits in its low positions and 1s in the positions above them. If exactly 4 bits follow, they form one complete nibble.
- R7: If 5 to 7 bits follow the last full byte, only the complete low nibble is output and the remaining bits are discarded.
- R8: With `pass_pre`=0, an `eof_in` pulse before the delimiter aborts the frame: neither `rx_dv` nor `crs` rises, and the next frame is received normally.
- R9: After reset `rx_dv` and `crs` are low, and `rxd` is 0 whenever `rx_dv` is low.
- R10: `rx_dv` changes only on clock edges where `nib_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-clock strobe qualifying `bit_in` |
| bit_in | input | 1 | Recovered serial bit |
| eof_in | input | 1 | One-clock end-of-frame (carrier lost) pulse |
| nib_en | input | 1 | 2.5 MHz nibble clock enable |
| pass_pre | input | 1 | 1: forward the preamble, 0: strip it |
| crs_align | input | 1 | 1: `crs` falls with `rx_dv` |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |

## Verification
On every cycle the assertions check several fixed relations. `rx_dv` may change only on nibble enables, and `rxd` must be zero when idle. In strip mode `crs` must lead `rx_dv`; in pass mode the two must rise together; with alignment on they must fall together. A padded dribble nibble must carry a 1 in its top bit. An aborted frame must never show carrier, and the nibble queue must neither overflow nor underflow. Only the bench scenarios can show that the nibble sequence is correct for whole frames in both preamble modes. They also show the exact edge where `crs` rises and falls relative to the delimiter and the end-of-frame pulse, how each dribble length is padded or cut, and that a frame after an abort is received normally.

// File: rtl/rxnf_pkg.sv
package rxnf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA} rx_state_e;

  localparam logic [3:0] SFD_LO = 4'h5;
  localparam logic [3:0] SFD_HI = 4'hD;

  // Partial nibble: the n newest bits sit at the top of sh (shifted in
  // at bit 3). Move them to the bottom and fill the rest with ones.
  function automatic logic [3:0] pad_nibble(input logic [3:0] sh, input logic [1:0] n);
    logic [3:0] got;
    got = sh >> (3'd4 - {1'b0, n});
    return got | (4'hF << n);
  endfunction

  // Dribble nibble is emitted only for 1..3 bits in the low half of a byte.
  function automatic logic dribble_emits(input logic [2:0] bits_in_byte);
    return (bits_in_byte[1:0] != 2'd0) && !bits_in_byte[2];
  endfunction
endpackage

// File: rtl/rxnf_bit_pack.sv
module rxnf_bit_pack
  import rxnf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       eof_in,
  input  logic       pass_pre,
  input  logic       accept,
  output logic       push,
  output logic [3:0] push_nib,
  output logic       sfd_hit,
  output logic       frame_end,
  output logic       abort
);
  rx_state_e  state, nxt_state;
  logic       prev_bit;
  logic [3:0] sh, sh_n;
  logic [2:0] bcnt, base, cnt_n;
  logic       pend;
  logic       pack, cnt_clr;

  always_comb begin
    nxt_state = state;
    push      = 1'b0;
    push_nib  = 4'h0;
    sfd_hit   = 1'b0;
    frame_end = 1'b0;
    abort     = 1'b0;
    pack      = 1'b0;
    cnt_clr   = 1'b0;
    case (state)
      ST_IDLE: if (bit_en && accept && bit_in) begin
        nxt_state = ST_PRE;
        pack      = pass_pre;
        cnt_clr   = 1'b1;
      end
      ST_PRE: if (eof_in) begin
        nxt_state = ST_IDLE;
        if (pass_pre) begin
          frame_end = 1'b1;
          if (dribble_emits(bcnt)) begin
            push     = 1'b1;
            push_nib = pad_nibble(sh, bcnt[1:0]);
          end
        end else begin
          abort = 1'b1;
        end
      end else if (bit_en) begin
        pack = pass_pre;
        if (prev_bit && bit_in) begin
          sfd_hit   = 1'b1;
          nxt_state = ST_DATA;
          if (!pass_pre) begin
            pack     = 1'b0;
            cnt_clr  = 1'b1;
            push     = 1'b1;
            push_nib = SFD_LO;
          end
        end
      end
      ST_DATA: begin
        if (pend) begin
          push     = 1'b1;
          push_nib = SFD_HI;
        end
        if (eof_in) begin
          nxt_state = ST_IDLE;
          frame_end = 1'b1;
          if (!pend && dribble_emits(bcnt)) begin
            push     = 1'b1;
            push_nib = pad_nibble(sh, bcnt[1:0]);
          end
        end else if (bit_en) begin
          pack = 1'b1;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
    base  = cnt_clr ? 3'd0 : bcnt;
    sh_n  = {bit_in, sh[3:1]};
    cnt_n = base + 3'd1;
    if (pack && base[1:0] == 2'd3) begin
      push     = 1'b1;
      push_nib = sh_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      prev_bit <= 1'b0;
      sh       <= 4'h0;
      bcnt     <= 3'd0;
      pend     <= 1'b0;
    end else begin
      state <= nxt_state;
      if (bit_en && state != ST_DATA) prev_bit <= bit_in;
      if (pack) begin
        sh   <= sh_n;
        bcnt <= cnt_n;
      end else if (cnt_clr) begin
        bcnt <= 3'd0;
      end
      if (sfd_hit && !pass_pre) pend <= 1'b1;
      else if (state == ST_DATA) pend <= 1'b0;
    end
  end

  // R2: the high delimiter nibble follows the low one on the next clock
  p_sfd_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sfd_hit && !pass_pre) |-> (push && push_nib == SFD_HI));
  // R6: a dribble nibble always has its top position filled with 1
  p_dribble_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && push && !$past(sfd_hit)) |-> push_nib[3]);
endmodule

// File: rtl/rxnf_nib_fifo.sv
module rxnf_nib_fifo #(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [3:0]               din,
  input  logic                     pop,
  output logic [3:0]               dout,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [3:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 4'h0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      count <= count + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  // R1: nibbles are never lost to a full queue
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && !pop && count == FULL));
  // R1: nothing is shown from an empty queue
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/rxnf_mii_drive.sv
module rxnf_mii_drive #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nib_en,
  input  logic          pass_pre,
  input  logic          crs_align,
  input  logic          sfd_hit,
  input  logic          frame_end,
  input  logic [CW-1:0] q_cnt,
  input  logic [3:0]    q_dout,
  output logic          pop,
  output logic [3:0]    rxd,
  output logic          rx_dv,
  output logic          crs,
  output logic          busy
);
  logic done, start, cont, stop, drop_done, crs_set, crs_clr;

  always_comb begin
    start     = nib_en && !rx_dv && (q_cnt >= CW'(2) || (done && q_cnt != '0));
    cont      = nib_en && rx_dv && q_cnt != '0;
    stop      = nib_en && rx_dv && q_cnt == '0 && done;
    drop_done = nib_en && !rx_dv && q_cnt == '0 && done;
    pop       = start || cont;
    crs_set   = (!pass_pre && sfd_hit) || (pass_pre && start && !done);
    crs_clr   = (!crs_align && frame_end) || (crs_align && stop);
    busy      = rx_dv || done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd   <= 4'h0;
      rx_dv <= 1'b0;
      crs   <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (pop) begin
        rxd   <= q_dout;
        rx_dv <= 1'b1;
      end else if (stop) begin
        rxd   <= 4'h0;
        rx_dv <= 1'b0;
      end
      if (frame_end) done <= 1'b1;
      else if (stop || drop_done) done <= 1'b0;
      if (crs_clr) crs <= 1'b0;
      else if (crs_set) crs <= 1'b1;
    end
  end

  // R10: valid only moves on a nibble enable
  p_dv_on_nib_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_dv) |-> $past(nib_en));
  // R9: idle data lines are zero
  p_rxd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> rxd == 4'h0);
  // R2: in strip mode carrier is already up when valid rises
  p_strip_crs_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_pre && $rose(rx_dv)) |-> $past(crs));
  // R3: in pass mode carrier and valid rise together
  p_pass_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_pre && $rose(rx_dv) && !$past(done)) |-> $rose(crs));
  // R4: unaligned carrier drops right after the end-of-frame pulse
  p_crs_eof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!crs_align && $past(frame_end)) |-> !crs);
  // R5: aligned carrier falls with valid
  p_align_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_align && $fell(rx_dv)) |-> !crs);
endmodule

// File: rtl/rx_nibble_fmt.sv
module rx_nibble_fmt #(
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       eof_in,
  input  logic       nib_en,
  input  logic       pass_pre,
  input  logic       crs_align,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       crs
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic          push, pop, sfd_hit, frame_end, abort, busy;
  logic [3:0]    push_nib, q_dout;
  logic [CW-1:0] q_cnt;

  rxnf_bit_pack u_pack (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .eof_in(eof_in), .pass_pre(pass_pre), .accept(!busy),
    .push(push), .push_nib(push_nib), .sfd_hit(sfd_hit),
    .frame_end(frame_end), .abort(abort)
  );

  rxnf_nib_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_nib),
    .pop(pop), .dout(q_dout), .count(q_cnt)
  );

  rxnf_mii_drive #(.CW(CW)) u_drive (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .pass_pre(pass_pre),
    .crs_align(crs_align), .sfd_hit(sfd_hit), .frame_end(frame_end),
    .q_cnt(q_cnt), .q_dout(q_dout), .pop(pop), .rxd(rxd),
    .rx_dv(rx_dv), .crs(crs), .busy(busy)
  );

  // R8: an aborted frame never shows carrier or valid
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!crs && !rx_dv));
endmodule

// File: tb/rx_nibble_fmt_bench.sv
module rx_nibble_fmt_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, eof_in = 1'b0;
  logic nib_en = 1'b0, pass_pre = 1'b0, crs_align = 1'b0;
  logic [3:0] rxd;
  logic rx_dv, crs;

  rx_nibble_fmt u_rx_nibble_fmt (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .eof_in(eof_in), .nib_en(nib_en), .pass_pre(pass_pre),
    .crs_align(crs_align), .rxd(rxd), .rx_dv(rx_dv), .crs(crs)
  );

  int errors = 0, checks = 0;
  int cyc = 0;
  int ncnt = 0;
  logic nib_q = 1'b0;
  always @(posedge clk) begin
    cyc   <= cyc + 1;
    nib_q <= nib_en;
  end
  always @(negedge clk) begin
    ncnt   <= (ncnt + 1) % 16;
    nib_en <= (ncnt == 0);
  end

  // monitor
  logic prev_dv = 1'b0, prev_crs = 1'b0;
  int dv_rise, dv_fall, crs_rise, crs_fall, nrec;
  int dv_off_nib = 0, idle_bad = 0;
  logic [3:0] rec [64];
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_dv && !prev_dv) dv_rise = cyc;
      if (!rx_dv && prev_dv) dv_fall = cyc;
      if (crs && !prev_crs) crs_rise = cyc;
      if (!crs && prev_crs) crs_fall = cyc;
      if (rx_dv != prev_dv && !nib_q) dv_off_nib++;
      if (!rx_dv && rxd != 4'h0) idle_bad++;
      if (nib_q && rx_dv && nrec < 64) begin
        rec[nrec] = rxd;
        nrec++;
      end
    end
    prev_dv  = rx_dv;
    prev_crs = crs;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] data_byte(input int i);
    return 8'(8'h3C ^ (i * 37) ^ (i << 5));
  endfunction

  int sfd_cyc, eof_cyc;
  logic [3:0] expn [64];
  int nexp;

  task automatic clear_mon();
    @(negedge clk);
    dv_rise = -1; dv_fall = -1; crs_rise = -1; crs_fall = -1; nrec = 0;
  endtask

  task automatic send_bit(input logic b);
    repeat (3) @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'b0;
  endtask

  task automatic send_eof();
    repeat (3) @(negedge clk);
    eof_in  = 1'b1;
    eof_cyc = cyc;
    @(negedge clk);
    eof_in = 1'b0;
  endtask

  // Sends a frame and checks the nibble stream against an expectation
  // built from whole bytes and the dribble rule.
  task automatic run_frame(input bit pass, input bit align, input int nbytes,
                           input int drib, input logic [7:0] dpat, input string req);
    pass_pre  = pass;
    crs_align = align;
    clear_mon();
    nexp = 0;
    for (int p = 0; p < 8; p++) begin
      logic [7:0] pb;
      pb = (p == 7) ? 8'hD5 : 8'h55;
      for (int b = 0; b < 8; b++) begin
        send_bit(pb[b]);
        if (p == 7 && b == 7) sfd_cyc = cyc - 1;
      end
      if (pass || p == 7) begin
        expn[nexp] = pb[3:0]; expn[nexp+1] = pb[7:4]; nexp += 2;
      end
    end
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] db;
      db = data_byte(i);
      for (int b = 0; b < 8; b++) send_bit(db[b]);
      expn[nexp] = db[3:0]; expn[nexp+1] = db[7:4]; nexp += 2;
    end
    for (int b = 0; b < drib; b++) send_bit(dpat[b]);
    if (drib >= 1 && drib <= 3) begin
      logic [3:0] v;
      v = 4'hF;
      for (int b = 0; b < drib; b++) v[b] = dpat[b];
      expn[nexp] = v; nexp++;
    end else if (drib >= 4) begin
      expn[nexp] = dpat[3:0]; nexp++;
    end
    send_eof();
    repeat (200) @(negedge clk);
    check(nrec == nexp, req, "nibble count", nrec, nexp);
    begin
      int bad;
      bad = -1;
      for (int k = 0; k < nexp && k < nrec; k++)
        if (bad < 0 && rec[k] !== expn[k]) bad = k;
      if (bad >= 0) check(1'b0, req, "nibble value", int'(rec[bad]), int'(expn[bad]));
      else check(1'b1, req, "nibble values", 0, 0);
    end
    check(!rx_dv && !crs, req, "idle after frame", int'(rx_dv) + int'(crs), 0);
  endtask

  task automatic t_reset();
    check(rx_dv == 1'b0, "R9", "rx_dv at reset", int'(rx_dv), 0);
    check(crs == 1'b0, "R9", "crs at reset", int'(crs), 0);
    check(rxd == 4'h0, "R9", "rxd at reset", int'(rxd), 0);
  endtask

  // R1 R2 R4: strip mode, carrier not aligned
  task automatic t_strip_basic();
    run_frame(1'b0, 1'b0, 4, 0, 8'h00, "R2");
    check(crs_rise == sfd_cyc + 1, "R2", "crs rise after delimiter", crs_rise, sfd_cyc + 1);
    check(crs_rise < dv_rise, "R2", "crs before rx_dv", crs_rise, dv_rise);
    check(crs_fall == eof_cyc + 1, "R4", "crs fall after eof", crs_fall, eof_cyc + 1);
    check(dv_fall > crs_fall, "R4", "rx_dv falls later", dv_fall, crs_fall);
    check(rec[2] == data_byte(0)[3:0], "R1", "low nibble first", int'(rec[2]), int'(data_byte(0)[3:0]));
  endtask

  // R3: preamble forwarded
  task automatic t_pass();
    run_frame(1'b1, 1'b0, 3, 0, 8'h00, "R3");
    check(crs_rise == dv_rise, "R3", "crs rises with rx_dv", crs_rise, dv_rise);
  endtask

  // R5: carrier aligned to rx_dv
  task automatic t_align();
    run_frame(1'b0, 1'b1, 2, 0, 8'h00, "R5");
    check(crs_fall == dv_fall, "R5", "crs falls with rx_dv", crs_fall, dv_fall);
    run_frame(1'b1, 1'b1, 2, 0, 8'h00, "R5");
    check(crs_fall == dv_fall, "R5", "pass crs falls with rx_dv", crs_fall, dv_fall);
  endtask

  // R6 R7: dribble lengths
  task automatic t_dribble();
    run_frame(1'b0, 1'b0, 2, 2, 8'b0000_0010, "R6");
    run_frame(1'b0, 1'b0, 2, 1, 8'b0000_0000, "R6");
    run_frame(1'b0, 1'b0, 2, 4, 8'b0000_0110, "R6");
    run_frame(1'b0, 1'b1, 2, 6, 8'b0010_1001, "R7");
    run_frame(1'b1, 1'b0, 1, 3, 8'b0000_0101, "R6");
    run_frame(1'b1, 1'b0, 1, 7, 8'b0101_1100, "R7");
  endtask

  // R8: abort before delimiter, then a good frame
  task automatic t_abort();
    pass_pre  = 1'b0;
    crs_align = 1'b0;
    clear_mon();
    for (int b = 0; b < 20; b++) send_bit(b % 2 == 0);
    send_eof();
    repeat (100) @(negedge clk);
    check(dv_rise == -1, "R8", "no rx_dv on abort", dv_rise, -1);
    check(crs_rise == -1, "R8", "no crs on abort", crs_rise, -1);
    check(nrec == 0, "R8", "no nibbles on abort", nrec, 0);
    run_frame(1'b0, 1'b0, 2, 0, 8'h00, "R8");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_strip_basic();
    t_pass();
    t_align();
    t_dribble();
    t_abort();
    check(dv_off_nib == 0, "R10", "rx_dv moved off nib_en", dv_off_nib, 0);
    check(idle_bad == 0, "R9", "rxd nonzero while idle", idle_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule